// File: doc/BRIEF.md
# Memory Address Decode and Exception Unit

This block sits between a processor's address path and the memory system. For every access it sees, it works out which target the address belongs to: boot ROM, main RAM or the 256-byte control register window. It raises that target's select line in the same cycle. An address that lands in none of them, or lands beyond the currently configured size of ROM or RAM, produces a one-cycle exception flag instead of a select.

The decoded ROM and RAM sizes are not fixed. They come from two small fields in a configuration word that lives inside the register window. After reset they give the smallest sizes, and software must widen them to match the memory that is fitted.

A control word in the same window can turn on write protection for RAM. When protection is on, a RAM write must fall inside one of two programmable segments, or it is refused with an exception. Every other word of the window has no function. Such a word is plain storage that reads back what was last written to it.

Top module: `memmap_decoder`

## Requirements
- R1: A ROM access (base 0x00000000) is selected when its address is below 4 KB shifted left by the ROM size field (configuration word bits [2:0]), which gives 512 KB at field value 7.
- R2: A RAM access (base 0x02000000) is selected when its offset from the base is below 256 KB shifted left by the RAM size field (configuration word bits [6:4]). Field values of 4 and above all give 4 MB.
- R3: After reset every window word reads as zero, so 4 KB of ROM and 256 KB of RAM are decoded and protection is off.
- R4: An access to an address that maps to no decoded region asserts `exc_pulse` in the same cycle, with every select low.
- R5: Any address from 0x01F80000 to 0x01F800FF selects the window and never raises an exception. A read returns the word last written at the same word index (address bits [7:2]). A write takes effect from the next cycle.
- R6: A window word with no function (every index except 0 to 5) is plain storage. Writing it changes no decode and no protection result.
- R7: The configuration word is window index 1 (offset 0x04). Only bits [2:0] and [6:4] affect decode.
- R8: The control word is window index 0 (offset 0x00). Only bit 3 enables protection.
- R9: With protection on, a RAM write is allowed only if its 8-byte unit (offset from the RAM base shifted right by 3) satisfies start <= unit < end for segment 0 (start at index 2, end at index 3) or segment 1 (start at index 4, end at index 5), using bits [18:0] of each word. Otherwise it raises `exc_pulse` and `sel_ram` stays low. RAM reads are never refused.
- R10: With `acc_valid` low, all selects and `exc_pulse` are low. At most one select is high at a time.
- R11: `rd_data` is zero except during a read of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Byte address of the access |
| acc_wdata | input | 32 | Write data (used for window writes) |
| sel_rom | output | 1 | ROM target selected |
| sel_ram | output | 1 | RAM target selected |
| sel_reg | output | 1 | Register window selected |
| exc_pulse | output | 1 | Memory exception for this access |
| rd_data | output | 32 | Read data from the register window |

## Verification
The hardest case to reach is a RAM write refused by protection. It needs the control bit set and both segment bounds programmed so that some addresses fall between, inside and past the segments, all through window writes made earlier.

Directed sequences therefore program the bounds first, then probe the unit just before each start, exactly at each start, at end minus one and exactly at each end, with protection both on and off. Random traffic also writes random words into the functional offsets. That brings up size and protection combinations that no directed case lists.

// File: rtl/mmd_pkg.sv
// Package: shared constants and types for the address decode unit.
// Assumes 32-bit byte addresses and a word-organised register window.
package mmd_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int WIN_LG     = 8;             // window is 2**WIN_LG bytes
    localparam int SIZE_F_W   = 3;             // width of each size field
    localparam int ROM_MIN_LG = 12;            // 4 KB
    localparam int ROM_MAX_LG = 19;            // 512 KB
    localparam int RAM_MIN_LG = 18;            // 256 KB
    localparam int RAM_MAX_LG = 22;            // 4 MB
    localparam int UNIT_LG    = 3;             // protection granule, 8 bytes
    localparam int NUM_SEG    = 2;             // protection segments

    localparam logic [ADDR_W-1:0] ROM_BASE = 32'h0000_0000;
    localparam logic [ADDR_W-1:0] RAM_BASE = 32'h0200_0000;
    localparam logic [ADDR_W-1:0] WIN_BASE = 32'h01F8_0000;

    // word indices and bit positions inside the window
    localparam int IDX_CTRL  = 0;
    localparam int IDX_MCFG  = 1;
    localparam int IDX_BND0  = 2;
    localparam int PROT_BIT  = 3;
    localparam int ROM_F_LSB = 0;
    localparam int RAM_F_LSB = 4;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_WIN  = 2'd3
    } target_e;

    // Size exponent: minimum plus field value, limited to the maximum.
    function automatic int clamp_lg(input int min_lg, input int field, input int max_lg);
        int lg;
        lg = min_lg + field;
        if (lg > max_lg) lg = max_lg;
        return lg;
    endfunction
endpackage

// File: rtl/mmd_region.sv
// Region classifier: maps an address to ROM, RAM, window or nothing.
// Assumes each base is aligned to its region's maximum size and that
// the regions never overlap. Purely combinational.
module mmd_region
    import mmd_pkg::*;
#(
    parameter int                ADDR_W_P   = ADDR_W,
    parameter int                SIZE_F_W_P = SIZE_F_W,
    parameter int                WIN_LG_P   = WIN_LG,
    parameter int                ROM_MIN_P  = ROM_MIN_LG,
    parameter int                ROM_MAX_P  = ROM_MAX_LG,
    parameter int                RAM_MIN_P  = RAM_MIN_LG,
    parameter int                RAM_MAX_P  = RAM_MAX_LG,
    parameter logic [ADDR_W_P-1:0] ROM_BASE_P = ROM_BASE,
    parameter logic [ADDR_W_P-1:0] RAM_BASE_P = RAM_BASE,
    parameter logic [ADDR_W_P-1:0] WIN_BASE_P = WIN_BASE
) (
    input  logic [ADDR_W_P-1:0]   addr,
    input  logic [SIZE_F_W_P-1:0] rom_f,
    input  logic [SIZE_F_W_P-1:0] ram_f,
    output target_e               tgt
);
    localparam int EXT_W = ADDR_W_P + 1;

    logic [ADDR_W_P-1:0] rom_off, ram_off, win_off;
    logic [EXT_W-1:0]    rom_lim, ram_lim;
    logic [EXT_W-1:0]    win_lim;
    logic                in_rom, in_ram, in_win;

    // Offsets and limits for each region from the live size fields.
    always_comb begin
        rom_off = addr - ROM_BASE_P;
        ram_off = addr - RAM_BASE_P;
        win_off = addr - WIN_BASE_P;
        rom_lim = EXT_W'(1) << clamp_lg(ROM_MIN_P, int'(rom_f), ROM_MAX_P);
        ram_lim = EXT_W'(1) << clamp_lg(RAM_MIN_P, int'(ram_f), RAM_MAX_P);
        win_lim = EXT_W'(1) << WIN_LG_P;
        in_rom  = (addr >= ROM_BASE_P) && ({1'b0, rom_off} < rom_lim);
        in_ram  = (addr >= RAM_BASE_P) && ({1'b0, ram_off} < ram_lim);
        in_win  = (addr >= WIN_BASE_P) && ({1'b0, win_off} < win_lim);
    end

    // Choose one target; the window wins, then ROM, then RAM.
    always_comb begin
        if (in_win)      tgt = TGT_WIN;
        else if (in_rom) tgt = TGT_ROM;
        else if (in_ram) tgt = TGT_RAM;
        else             tgt = TGT_NONE;
    end
endmodule

// File: rtl/mmd_guard.sv
// Write-protection checker: refuses a RAM write whose 8-byte unit lies
// outside every programmed [start, end) segment while protection is on.
// Assumes the unit index is already relative to the RAM base.
module mmd_guard #(
    parameter int NUM_SEG_P = 2,
    parameter int BND_W_P   = 19
) (
    input  logic                                prot_en,
    input  logic                                ram_write,
    input  logic [BND_W_P-1:0]                  unit,
    input  logic [2*NUM_SEG_P-1:0][BND_W_P-1:0] bounds,
    output logic                                deny
);
    logic [NUM_SEG_P-1:0] seg_ok;

    // One window compare per segment.
    for (genvar s = 0; s < NUM_SEG_P; s++) begin : g_seg
        always_comb seg_ok[s] = (unit >= bounds[2*s]) && (unit < bounds[2*s+1]);
    end

    // Refuse only protected RAM writes that hit no segment.
    always_comb deny = prot_en && ram_write && !(|seg_ok);
endmodule

// File: rtl/mmd_winregs.sv
// Register window storage: one word per index, written on window writes
// and read combinationally. Functional fields are tapped out of fixed
// words; every other word is plain read-back storage.
// Assumes at most one write per cycle and synchronous active-low reset.
module mmd_winregs #(
    parameter int DATA_W_P   = 32,
    parameter int IDX_W_P    = 6,
    parameter int NUM_SEG_P  = 2,
    parameter int BND_W_P    = 19,
    parameter int SIZE_F_W_P = 3,
    parameter int IDX_CTRL_P = 0,
    parameter int IDX_MCFG_P = 1,
    parameter int IDX_BND_P  = 2,
    parameter int PROT_BIT_P = 3,
    parameter int ROM_LSB_P  = 0,
    parameter int RAM_LSB_P  = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W_P-1:0]                  idx,
    input  logic [DATA_W_P-1:0]                 wr_data,
    output logic [DATA_W_P-1:0]                 rd_word,
    output logic                                prot_en,
    output logic [SIZE_F_W_P-1:0]               rom_f,
    output logic [SIZE_F_W_P-1:0]               ram_f,
    output logic [2*NUM_SEG_P-1:0][BND_W_P-1:0] bounds
);
    localparam int WORDS = 1 << IDX_W_P;

    logic [DATA_W_P-1:0] mem [WORDS];

    // Clear all words on reset, else store the addressed word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    // Combinational read of the addressed word.
    always_comb rd_word = mem[idx];

    // Tap the functional fields out of their words.
    always_comb begin
        prot_en = mem[IDX_CTRL_P][PROT_BIT_P];
        rom_f   = mem[IDX_MCFG_P][ROM_LSB_P +: SIZE_F_W_P];
        ram_f   = mem[IDX_MCFG_P][RAM_LSB_P +: SIZE_F_W_P];
    end

    // Segment bounds, one word per bound, low bits only.
    for (genvar b = 0; b < 2*NUM_SEG_P; b++) begin : g_bnd
        always_comb bounds[b] = mem[IDX_BND_P + b][BND_W_P-1:0];
    end
endmodule

// File: rtl/memmap_decoder.sv
// Top of the address decode and exception unit. Classifies each access,
// applies write protection, drives one select or the exception flag in
// the same cycle, and serves register window reads and writes.
// Assumes one access per cycle, qualified by acc_valid.
module memmap_decoder
    import mmd_pkg::*;
#(
    parameter int NUM_SEG_P = NUM_SEG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_reg,
    output logic              exc_pulse,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = WIN_LG - 2;
    localparam int BND_W = RAM_MAX_LG - UNIT_LG;

    target_e                            tgt;
    logic [SIZE_F_W-1:0]                rom_f, ram_f;
    logic                               prot_en, deny, ram_write, win_wr;
    logic [DATA_W-1:0]                  rd_word;
    logic [2*NUM_SEG_P-1:0][BND_W-1:0]  bounds;

    mmd_region u_region (
        .addr  (acc_addr),
        .rom_f (rom_f),
        .ram_f (ram_f),
        .tgt   (tgt)
    );

    // Qualify write strobes per target.
    always_comb begin
        ram_write = acc_valid && acc_write && (tgt == TGT_RAM);
        win_wr    = acc_valid && acc_write && (tgt == TGT_WIN);
    end

    mmd_guard #(.NUM_SEG_P(NUM_SEG_P), .BND_W_P(BND_W)) u_guard (
        .prot_en   (prot_en),
        .ram_write (ram_write),
        .unit      (acc_addr[RAM_MAX_LG-1:UNIT_LG]),
        .bounds    (bounds),
        .deny      (deny)
    );

    mmd_winregs #(
        .DATA_W_P   (DATA_W),
        .IDX_W_P    (IDX_W),
        .NUM_SEG_P  (NUM_SEG_P),
        .BND_W_P    (BND_W),
        .SIZE_F_W_P (SIZE_F_W),
        .IDX_CTRL_P (IDX_CTRL),
        .IDX_MCFG_P (IDX_MCFG),
        .IDX_BND_P  (IDX_BND0),
        .PROT_BIT_P (PROT_BIT),
        .ROM_LSB_P  (ROM_F_LSB),
        .RAM_LSB_P  (RAM_F_LSB)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_wr),
        .idx     (acc_addr[WIN_LG-1:2]),
        .wr_data (acc_wdata),
        .rd_word (rd_word),
        .prot_en (prot_en),
        .rom_f   (rom_f),
        .ram_f   (ram_f),
        .bounds  (bounds)
    );

    // Drive selects, the exception flag and window read data.
    always_comb begin
        sel_rom   = acc_valid && (tgt == TGT_ROM);
        sel_ram   = acc_valid && (tgt == TGT_RAM) && !deny;
        sel_reg   = acc_valid && (tgt == TGT_WIN);
        exc_pulse = acc_valid && ((tgt == TGT_NONE) || deny);
        rd_data   = (acc_valid && !acc_write && (tgt == TGT_WIN)) ? rd_word : '0;
    end
endmodule

// File: rtl/mmd_checker.sv
// Checker for memmap_decoder: port-level temporal properties, bound in.
module mmd_checker
    import mmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              sel_rom,
    input logic              sel_ram,
    input logic              sel_reg,
    input logic              exc_pulse,
    input logic [DATA_W-1:0] rd_data
);
    logic in_win;
    always_comb in_win = (acc_addr >= 32'h01F8_0000) && (acc_addr <= 32'h01F8_00FF);

    p_onehot_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rom, sel_ram, sel_reg}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(sel_rom || sel_ram || sel_reg || exc_pulse));

    p_exc_no_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> !(sel_rom || sel_ram || sel_reg));

    p_far_exc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr >= 32'h0240_0000) |-> exc_pulse);

    p_win_no_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_win) |-> (sel_reg && !exc_pulse));

    p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && in_win) |=>
        (!(acc_valid && !acc_write && in_win && acc_addr[7:2] == $past(acc_addr[7:2]))
         || rd_data == $past(acc_wdata)));

    p_rom_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr < 32'h0000_1000) |-> sel_rom);

    p_ram_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_addr >= 32'h0200_0000 && acc_addr < 32'h0204_0000)
        |-> sel_ram);

    p_rdata_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write && sel_reg) |-> (rd_data == '0));
endmodule

bind memmap_decoder mmd_checker u_chk (.*);

// File: tb/tb_memmap_decoder.sv
module tb_memmap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_addr = '0, acc_wdata = '0;
    logic        sel_rom, sel_ram, sel_reg, exc_pulse;
    logic [31:0] rd_data;

    int n_checks = 0, n_fail = 0;
    logic [31:0] shadow [64];

    always #4 clk = ~clk;

    memmap_decoder dut (.*);

    // Expected outputs from the requirements for one access.
    function automatic void model(input logic [31:0] a, input logic wr,
                                  output logic [4:0] flags, output logic [31:0] rd);
        logic [31:0] rom_lim, ram_lim, u;
        logic ok;
        rom_lim = 32'h1000 << shadow[1][2:0];
        ram_lim = (shadow[1][6:4] > 3'd3) ? 32'h40_0000 : (32'h4_0000 << shadow[1][6:4]);
        flags = 5'b0;   // {rom, ram, reg, exc, unused}
        rd = '0;
        if (a >= 32'h01F8_0000 && a < 32'h01F8_0100) begin
            flags[2] = 1'b1;
            if (!wr) rd = shadow[a[7:2]];
        end else if (a < rom_lim) begin
            flags[4] = 1'b1;
        end else if (a >= 32'h0200_0000 && (a - 32'h0200_0000) < ram_lim) begin
            u  = (a - 32'h0200_0000) >> 3;
            ok = (u >= {13'b0, shadow[2][18:0]} && u < {13'b0, shadow[3][18:0]}) ||
                 (u >= {13'b0, shadow[4][18:0]} && u < {13'b0, shadow[5][18:0]});
            if (wr && shadow[0][3] && !ok) flags[1] = 1'b1;
            else flags[3] = 1'b1;
        end else begin
            flags[1] = 1'b1;
        end
    endfunction

    // Present one access, compare outputs, update the shadow on window writes.
    task automatic access(input logic [31:0] a, input logic wr, input logic [31:0] d,
                          input string req);
        logic [4:0]  ef;
        logic [31:0] erd;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        #1;
        model(a, wr, ef, erd);
        n_checks++;
        if ({sel_rom, sel_ram, sel_reg, exc_pulse} != ef[4:1] || rd_data != erd) begin
            n_fail++;
            $display("FAIL %s addr=%h wr=%0b: got sel/exc=%b rd=%h, expected %b rd=%h",
                     req, a, wr, {sel_rom, sel_ram, sel_reg, exc_pulse}, rd_data, ef[4:1], erd);
        end
        if (wr && ef[2]) shadow[a[7:2]] = d;
    endtask

    task automatic idle_check;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 32'h0200_0000; acc_wdata = '1;
        #1;
        n_checks++;
        if ({sel_rom, sel_ram, sel_reg, exc_pulse} != 4'b0 || rd_data != 0) begin
            n_fail++;
            $display("FAIL R10 idle: got %b rd=%h, expected 0000 rd=0",
                     {sel_rom, sel_ram, sel_reg, exc_pulse}, rd_data);
        end
    endtask

    function automatic logic [31:0] pick_addr(input int b);
        case (b)
            0: return $urandom_range(32'h0008_1000, 0);
            1: return 32'h0200_0000 + $urandom_range(32'h0048_0000, 0);
            2: return 32'h01F8_0000 + $urandom_range(32'h130, 0) - 32'h20;
            3: return $urandom;
            default: return 32'h0200_0000 + ($urandom_range(63, 0) << 3);
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R3: reset state of window and default sizes
        for (int i = 0; i < 64; i++) access(32'h01F8_0000 + 32'(i*4), 1'b0, 0, "R3");
        access(32'h0000_0FFC, 1'b0, 0, "R3 R1");
        access(32'h0000_1000, 1'b0, 0, "R3 R4");
        access(32'h0203_FFFC, 1'b1, 0, "R3 R2");
        access(32'h0204_0000, 1'b0, 0, "R3 R4");
        access(32'h0100_0000, 1'b0, 0, "R4");
        idle_check();

        // R7: full sizes, other config bits set
        access(32'h01F8_0004, 1'b1, 32'hFFFF_FF47, "R7");
        access(32'h0007_FFFC, 1'b0, 0, "R1 R7");
        access(32'h0008_0000, 1'b0, 0, "R1 R4");
        access(32'h023F_FFFC, 1'b0, 0, "R2 R7");
        access(32'h0240_0000, 1'b1, 0, "R2 R4");
        // R2: field 7 caps at 4 MB
        access(32'h01F8_0004, 1'b1, 32'h0000_0073, "R2");
        access(32'h023F_FFF8, 1'b1, 0, "R2");
        access(32'h0240_0000, 1'b0, 0, "R2 R4");
        access(32'h0000_7FFC, 1'b0, 0, "R1");
        access(32'h0000_8000, 1'b0, 0, "R1 R4");

        // R6: scratch words store and have no effect
        access(32'h01F8_0040, 1'b1, 32'hDEAD_BEEF, "R6");
        access(32'h01F8_0041, 1'b0, 0, "R6 R5");
        access(32'h01F8_00FC, 1'b1, 32'hFFFF_FFFF, "R6");
        access(32'h01F8_00FC, 1'b0, 0, "R6 R5");
        access(32'h0000_7FFC, 1'b0, 0, "R6");
        access(32'h0200_0000, 1'b1, 0, "R6");

        // R9: bounds seg0 [0x10,0x20), seg1 [0x100,0x101)
        access(32'h01F8_0008, 1'b1, 32'hFFF8_0010, "R9");
        access(32'h01F8_000C, 1'b1, 32'h0000_0020, "R9");
        access(32'h01F8_0010, 1'b1, 32'h0000_0100, "R9");
        access(32'h01F8_0014, 1'b1, 32'h0000_0101, "R9");
        // R8: other control bits do not enable protection
        access(32'h01F8_0000, 1'b1, 32'hFFFF_FFF7, "R8");
        access(32'h0200_0000, 1'b1, 0, "R8");
        access(32'h01F8_0000, 1'b1, 32'h0000_0008, "R8");
        access(32'h0200_0078, 1'b1, 0, "R9 below");
        access(32'h0200_0080, 1'b1, 0, "R9 start");
        access(32'h0200_00F8, 1'b1, 0, "R9 end-1");
        access(32'h0200_0100, 1'b1, 0, "R9 end");
        access(32'h0200_0800, 1'b1, 0, "R9 seg1");
        access(32'h0200_0808, 1'b1, 0, "R9 seg1 end");
        access(32'h0200_0100, 1'b0, 0, "R9 read");
        access(32'h0000_0100, 1'b1, 0, "R9 rom");
        idle_check();

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int b;
            b = $urandom_range(5, 0);
            if ($urandom_range(7, 0) == 0)
                access(32'h01F8_0000 + ($urandom_range(5, 0) << 2), 1'b1, $urandom, "R7 R8 R9");
            else
                access(pick_addr(b), 1'($urandom_range(1, 0)), $urandom, "R1 R2 R4 R5");
            if ($urandom_range(31, 0) == 0) idle_check();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule